// File: doc/BRIEF.md
# Vectored Interrupt Controller with Fixed Line Sensing

The block collects up to 32 interrupt sources into a single request line for a processor. Each source line has a sense type fixed at build time: it reacts either to a rising edge, to a falling edge, to a high level or to a low level. A detected event sets that line's bit in a status register. An enable register masks status into a pending view. The request output is raised while any pending bit is set and the master enable allows it.

Software uses a small word-addressed register bus. It can write the enable register directly, or change enable bits one at a time through a set-bits alias and a clear-bits alias. It clears serviced events by writing a mask to an acknowledge address. It learns which line to service by reading a vector register, which names the lowest-numbered pending line. The usual bring-up is to write the enable register to zero, acknowledge all ones, and then write 3 to the master enable.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, the status, enable and master enable registers are 0 and irq_req is low. The vector register reads all ones.
- R2: Word addresses (byte offset = 4 x word) map as follows: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master enable. The write-only addresses 3, 4 and 5 read as 0. Writes to status, pending and vector have no effect.
- R3: A write to word 4 sets the enable bits that are 1 in the data. All other enable bits keep their value.
- R4: A write to word 5 clears the enable bits that are 1 in the data. All other enable bits keep their value.
- R5: A write to word 2 loads the whole enable register.
- R6: A write to word 3 clears the status bit of each line whose data bit is 1. Writing all ones clears every latched bit that no new event sets in the same cycle.
- R7: Line n has a 2-bit sense code in bits [2n+1:2n] of parameter SENSE: 0 rising edge, 1 falling edge, 2 high level, 3 low level. The default makes line n use code n mod 4. An edge line sets status only in the cycle after its input changes in its sense direction.
- R8: A level line whose input is still active has its status bit set again after an acknowledge.
- R9: When a new event and an acknowledge hit the same status bit in the same cycle, the bit stays set.
- R10: The pending register reads as status AND enable.
- R11: The vector register returns the number of the lowest-numbered pending line. It returns 0xFFFFFFFF when nothing is pending.
- R12: The master enable register holds 2 bits, and bits 31:2 read 0. irq_req is high exactly when some pending bit is set and master bit 0 is 1.
- R13: While master bit 1 is 0, no input event sets a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_word | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq_src | input | NLINES | Interrupt source lines, synchronous to clk |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The embedded properties assume that irq_src is already synchronous to clk, so each line holds one sampled value per cycle. They also assume that a write changes at most one register per cycle, which follows from the bus having a single address. The bench drives every input on the falling edge and reads the combinational read data before the next rising edge, so every sample sees settled, cycle-aligned values. The random phase mostly keeps master enable at 3 so that events latch. It occasionally writes other values to cover the gated cases, and it flips a few source bits at a time so that edges on individual lines stay distinguishable.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NLINES = 32,
  parameter logic [2*NLINES-1:0] SENSE = 64'hE4E4_E4E4_E4E4_E4E4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_word,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NLINES-1:0] irq_src,
  output logic              irq_req
);
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1;
  localparam logic [2:0] W_STAT = 3'd0, W_PEND = 3'd1, W_EN  = 3'd2, W_ACK = 3'd3,
                         W_SET  = 3'd4, W_CLR  = 3'd5, W_VEC = 3'd6, W_MST = 3'd7;

  logic [NLINES-1:0] status, enable, hit, pending, wmask, ack_mask;
  logic [1:0]        master;
  logic [LW-1:0]     win;
  logic              any;

  assign wmask    = bus_wdata[NLINES-1:0];
  assign ack_mask = (bus_wr && bus_word == W_ACK) ? wmask : '0;
  assign pending  = status & enable;
  assign any      = |pending;
  assign irq_req  = any & master[0];

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    localparam logic [1:0] K = SENSE[2*i +: 2];
    if (K == 2'd0 || K == 2'd1) begin : g_edge
      logic prev;
      always_ff @(posedge clk)
        if (!rst_n) prev <= 1'b0;
        else        prev <= irq_src[i];
      if (K == 2'd0) begin : g_rise
        assign hit[i] = irq_src[i] & ~prev;
      end else begin : g_fall
        assign hit[i] = ~irq_src[i] & prev;
      end
    end else if (K == 2'd2) begin : g_high
      assign hit[i] = irq_src[i];
    end else begin : g_low
      assign hit[i] = ~irq_src[i];
    end
  end

  always_ff @(posedge clk)
    if (!rst_n) status <= '0;
    else        status <= (status & ~ack_mask) | (master[1] ? hit : '0);

  always_ff @(posedge clk)
    if (!rst_n) enable <= '0;
    else if (bus_wr)
      case (bus_word)
        W_EN:    enable <= wmask;
        W_SET:   enable <= enable | wmask;
        W_CLR:   enable <= enable & ~wmask;
        default: ;
      endcase

  always_ff @(posedge clk)
    if (!rst_n)                           master <= 2'b00;
    else if (bus_wr && bus_word == W_MST) master <= bus_wdata[1:0];

  always_comb begin
    win = '0;
    for (int i = NLINES - 1; i >= 0; i--)
      if (pending[i]) win = LW'(i);
  end

  always_comb
    case (bus_word)
      W_STAT:  bus_rdata = 32'(status);
      W_PEND:  bus_rdata = 32'(pending);
      W_EN:    bus_rdata = 32'(enable);
      W_VEC:   bus_rdata = any ? 32'(win) : '1;
      W_MST:   bus_rdata = {30'b0, master};
      default: bus_rdata = '0;
    endcase

  a_r3_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_word == W_SET) |=> ((enable & $past(wmask)) == $past(wmask)));
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_word == W_CLR) |=> ((enable & $past(wmask)) == '0));
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_word == W_ACK && !master[1]) |=> ((status & $past(wmask)) == '0));
  a_r13_gate_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !master[1] |=> ((status & ~$past(status)) == '0));
  a_r12_req_master: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (master[0] && pending != '0));
  a_r11_vec_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_word == W_VEC && any) |->
      (pending[win] && (pending & ((NLINES'(1) << win) - NLINES'(1))) == '0));
  a_r11_vec_none: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_word == W_VEC && !any) |-> (bus_rdata == 32'hFFFF_FFFF));
endmodule

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, irq_req;
  logic [2:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, irq_src = '0;
  int ntests = 0, nfail = 0;
  bit done = 0;

  logic [31:0] m_stat, m_en, m_prev;
  logic [1:0]  m_mst;

  vec_irq_ctrl dut (.clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src), .irq_req(irq_req));

  always #5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] events(logic [31:0] s);
    logic [31:0] e;
    for (int i = 0; i < 32; i++)
      case (i % 4)
        0: e[i] = s[i] & ~m_prev[i];
        1: e[i] = ~s[i] & m_prev[i];
        2: e[i] = s[i];
        default: e[i] = ~s[i];
      endcase
    return e;
  endfunction

  function automatic logic [31:0] m_read(logic [2:0] a);
    logic [31:0] p = m_stat & m_en;
    case (a)
      0: return m_stat;
      1: return p;
      2: return m_en;
      6: begin
        for (int i = 0; i < 32; i++) if (p[i]) return 32'(i);
        return 32'hFFFF_FFFF;
      end
      7: return {30'b0, m_mst};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] a);
    case (a)
      0: return "R7 status";
      1: return "R10 pending";
      2: return "R5 enable";
      6: return "R11 vector";
      7: return "R12 master";
      default: return "R2 write-only";
    endcase
  endfunction

  task automatic step(logic w, logic [2:0] a, logic [31:0] d, logic [31:0] s);
    logic [31:0] ack;
    bus_wr = w; bus_word = a; bus_wdata = d; irq_src = s;
    #1;
    if (!w) check(tag_of(a), bus_rdata, m_read(a));
    check("R12 irq_req", 32'(irq_req), 32'(((m_stat & m_en) != 0) && m_mst[0]));
    @(posedge clk);
    ack = (w && a == 3) ? d : 32'h0;
    m_stat = (m_stat & ~ack) | (m_mst[1] ? events(s) : 32'h0);
    if (w)
      case (a)
        2: m_en = d;
        4: m_en = m_en | d;
        5: m_en = m_en & ~d;
        7: m_mst = d[1:0];
        default: ;
      endcase
    m_prev = s;
    @(negedge clk);
  endtask

  task automatic expect_bits(logic [2:0] a, logic [31:0] mask, logic [31:0] exp, string tag);
    bus_wr = 1'b0; bus_word = a;
    #1;
    check(tag, bus_rdata & mask, exp);
    step(1'b0, a, 32'h0, irq_src);
  endtask

  localparam logic [31:0] QUIET = 32'h8888_8888;

  initial begin
    #(10 * 200000);
    if (!done) begin
      ntests++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_stat = 0; m_en = 0; m_prev = 0; m_mst = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    for (int a = 0; a < 8; a++) step(1'b0, 3'(a), 32'h0, 32'h0);
    expect_bits(6, '1, 32'hFFFF_FFFF, "R1 vector after reset");
    expect_bits(0, '1, 32'h0, "R1 status after reset");
    // R13 no latching while master bit 1 is 0
    repeat (3) step(1'b0, 0, 32'h0, 32'hFFFF_FFFF);
    step(1'b0, 0, 32'h0, 32'h0);
    expect_bits(0, '1, 32'h0, "R13 gated status");
    // R12 master width
    step(1'b1, 7, 32'hFFFF_FFFF, QUIET);
    expect_bits(7, '1, 32'h3, "R12 master reads two bits");
    // R2 writes to read-only words ignored
    step(1'b1, 3, 32'hFFFF_FFFF, QUIET);
    step(1'b1, 0, 32'hFFFF_FFFF, QUIET);
    step(1'b1, 6, 32'hFFFF_FFFF, QUIET);
    expect_bits(0, '1, 32'h0, "R2 status write ignored");
    // R7 rising edge once
    step(1'b0, 0, 32'h0, QUIET | 32'h1);
    expect_bits(0, 32'h1, 32'h1, "R7 rising edge latched");
    step(1'b1, 3, 32'h1, QUIET | 32'h1);
    step(1'b0, 0, 32'h0, QUIET | 32'h1);
    expect_bits(0, 32'h1, 32'h0, "R7 held edge line stays clear");
    // R8 level line re-sets after ack
    step(1'b0, 0, 32'h0, QUIET | 32'h5);
    step(1'b1, 3, 32'h4, QUIET | 32'h5);
    expect_bits(0, 32'h4, 32'h4, "R8 level line re-latched");
    // R6 ack all with quiet sources
    step(1'b1, 3, 32'hFFFF_FFFF, QUIET);
    step(1'b1, 3, 32'hFFFF_FFFF, QUIET);
    expect_bits(0, '1, 32'h0, "R6 ack all ones");
    // R9 event and ack in same cycle
    step(1'b1, 3, 32'h1, QUIET | 32'h1);
    expect_bits(0, 32'h1, 32'h1, "R9 event beats ack");
    step(1'b1, 3, '1, QUIET);
    // R11 / R3 / R4 vector ordering
    step(1'b1, 4, 32'h0000_1010, QUIET);
    step(1'b0, 0, 32'h0, QUIET | 32'h0000_1010);
    expect_bits(6, '1, 32'd4, "R11 lowest pending line");
    check("R12 irq raised", 32'(irq_req), 32'h1);
    step(1'b1, 5, 32'h0000_0010, QUIET | 32'h0000_1010);
    expect_bits(6, '1, 32'd12, "R4 cleared enable moves vector");
    expect_bits(2, '1, 32'h0000_1000, "R3 set bits kept");
    step(1'b1, 7, 32'h2, QUIET | 32'h0000_1010);
    check("R12 irq masked by master", 32'(irq_req), 32'h0);
    expect_bits(1, '1, 32'h0000_1000, "R10 pending view");
    step(1'b1, 3, '1, QUIET | 32'h0000_1010);
    expect_bits(6, '1, 32'hFFFF_FFFF, "R11 nothing pending");
    step(1'b1, 7, 32'h3, QUIET);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] d, s;
      logic [2:0]  a = 3'($urandom % 8);
      logic        w = ($urandom % 2) == 0;
      case ($urandom % 4)
        0: d = $urandom;
        1: d = 32'h1 << ($urandom % 32);
        2: d = 32'hFFFF_FFFF;
        default: d = ~(32'h1 << ($urandom % 32));
      endcase
      if (a == 7) d = (($urandom % 5) == 0) ? $urandom : 32'h3;
      s = irq_src;
      if (($urandom % 3) == 0) s = s ^ (32'h1 << ($urandom % 32));
      if (($urandom % 50) == 0) s = $urandom;
      step(w, a, d, s);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule